// File: doc/BRIEF.md
# Calendar Month Length Decoder

This block tells a watch display how long the current month is. It takes the year as four packed BCD digits and the month as a 4-bit binary number. From these it produces four one-hot lines that mark a month of 28, 29, 30 or 31 days. The leap-year flag it computes internally is also brought out as a port.

The leap decision uses no division. Divisibility by 4 depends only on the low bit of the tens digit and the two low bits of the ones digit. A year is a century when its two low digits are both zero. The same divisible-by-4 test, applied to the thousands and hundreds pair, decides whether a century year is a multiple of 400.

The block is purely combinational, so its outputs follow the inputs with no latency. Year digits with codes 10 to 15 are not valid BCD, and the outputs for them are not specified.

Top module: `cal_month_days`

## Requirements
- R1: `year_bcd` holds the thousands digit in bits [15:12], hundreds in [11:8], tens in [7:4] and ones in [3:0], each as a BCD code 0 to 9.
- R2: `leap_year` is 1 for a year divisible by 4 and not divisible by 100.
- R3: `leap_year` is 0 for a year divisible by 100 and not divisible by 400.
- R4: `leap_year` is 1 for a year divisible by 400, including year 0000.
- R5: `leap_year` is 0 for a year not divisible by 4.
- R6: For month 2, `days_onehot` is 4'b0010 (bit 1, 29 days) when `leap_year` is 1, and 4'b0001 (bit 0, 28 days) otherwise.
- R7: Months 4, 6, 9 and 11 give `days_onehot` = 4'b0100 (bit 2, 30 days) for every year.
- R8: Months 1, 3, 5, 7, 8, 10 and 12 give `days_onehot` = 4'b1000 (bit 3, 31 days) for every year.
- R9: Month codes 0, 13, 14 and 15 drive all four `days_onehot` lines low for every year.
- R10: `days_onehot` never has more than one bit set, and for months 1 to 12 it has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| year_bcd | input | 16 | Year as four BCD digits, thousands digit in the top nibble |
| month | input | 4 | Month number in binary, 1 to 12 valid |
| leap_year | output | 1 | High when the year is a leap year |
| days_onehot | output | 4 | One-hot month length: bit 0 = 28, bit 1 = 29, bit 2 = 30, bit 3 = 31 |

## Verification
The hardest cases to reach are the century years. The high digit pair decides the result only when both low digits are zero, so a leap rule with the wrong term order gives a wrong answer in only 75 of the 10000 valid years. The stimulus therefore sweeps every year from 0000 to 9999 against every month code. For each pair it compares both outputs with an integer modulo reference that works on the decoded year value. A short vector table and directed century cases come before the sweep, so that a failure points to a named requirement.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DIG_W     = 4;
  localparam int NUM_DIGS  = 4;
  localparam int YEAR_W    = DIG_W * NUM_DIGS;
  localparam int NUM_PAIRS = NUM_DIGS / 2;
  localparam int MON_W     = 4;
  localparam int LEN_W     = 4;

  typedef logic [DIG_W-1:0] bcd_digit_t;

  typedef enum logic [1:0] {
    LEN_28 = 2'd0,
    LEN_29 = 2'd1,
    LEN_30 = 2'd2,
    LEN_31 = 2'd3
  } len_idx_e;
endpackage

// File: rtl/bcd_pair_div4.sv
module bcd_pair_div4
  import cal_pkg::*;
(
  input  bcd_digit_t hi_digit,
  input  bcd_digit_t lo_digit,
  output logic       div4
);
  // 20*k is a multiple of 4; an odd tens digit adds 10, which is 2 mod 4.
  logic hi_odd;
  logic lo_mod4_zero;
  logic lo_mod4_two;

  always_comb begin
    hi_odd       = hi_digit[0];
    lo_mod4_zero = ~lo_digit[1] & ~lo_digit[0];
    lo_mod4_two  =  lo_digit[1] & ~lo_digit[0];
    div4         = (~hi_odd & lo_mod4_zero) | (hi_odd & lo_mod4_two);
  end
endmodule

// File: rtl/year_leap_rule.sv
module year_leap_rule
  import cal_pkg::*;
(
  input  logic [YEAR_W-1:0] year_bcd,
  output logic              leap
);
  logic [NUM_PAIRS-1:0] pair_div4;
  logic                 low_zero;
  logic                 is_century;
  logic                 is_quad_century;

  // Pair 0: tens/ones. Pair 1: thousands/hundreds.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    bcd_pair_div4 u_div4 (
      .hi_digit (year_bcd[(2*p+1)*DIG_W +: DIG_W]),
      .lo_digit (year_bcd[(2*p)*DIG_W   +: DIG_W]),
      .div4     (pair_div4[p])
    );
  end

  always_comb begin
    low_zero        = ~|year_bcd[2*DIG_W-1:0];
    is_century      = low_zero;
    is_quad_century = low_zero & pair_div4[1];
    leap            = (pair_div4[0] & ~is_century) | is_quad_century;
  end

  always_comb begin
    assert_century_not_leap_R3 : assert (!(is_century && !is_quad_century) || !leap);
    assert_quad_century_leap_R4 : assert (!is_quad_century || leap);
    assert_not_div4_not_leap_R5 : assert (pair_div4[0] || !leap);
  end
endmodule

// File: rtl/month_len_decode.sv
module month_len_decode
  import cal_pkg::*;
(
  input  logic [MON_W-1:0] month,
  input  logic             leap,
  output logic [LEN_W-1:0] days_onehot
);
  logic month_valid;

  always_comb begin
    days_onehot = '0;
    month_valid = 1'b1;
    case (month)
      4'd2:                        days_onehot[leap ? LEN_29 : LEN_28] = 1'b1;
      4'd4, 4'd6, 4'd9, 4'd11:     days_onehot[LEN_30] = 1'b1;
      4'd1, 4'd3, 4'd5, 4'd7,
      4'd8, 4'd10, 4'd12:          days_onehot[LEN_31] = 1'b1;
      default:                     month_valid = 1'b0;
    endcase
  end

  always_comb begin
    assert_at_most_one_R10 : assert ($onehot0(days_onehot));
    assert_valid_has_one_R10 : assert (!((month >= 4'd1) && (month <= 4'd12)) || ($countones(days_onehot) == 1));
    assert_bad_month_dark_R9 : assert (month_valid || (days_onehot == '0));
  end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
  import cal_pkg::*;
(
  input  logic [15:0] year_bcd,
  input  logic [3:0]  month,
  output logic        leap_year,
  output logic [3:0]  days_onehot
);
  logic leap_w;

  year_leap_rule u_leap (
    .year_bcd (year_bcd),
    .leap     (leap_w)
  );

  month_len_decode u_len (
    .month       (month),
    .leap        (leap_w),
    .days_onehot (days_onehot)
  );

  assign leap_year = leap_w;

  always_comb begin
    assert_feb_follows_leap_R6 : assert ((month != 4'd2) || (days_onehot == (leap_year ? 4'b0010 : 4'b0001)));
  end
endmodule

// File: tb/tb_cal_month_days.sv
module tb_cal_month_days;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int NVEC = 12;

  // {year_bcd, month, expected days, expected leap}
  localparam logic [24:0] VECS [NVEC] = '{
    {16'h2024, 4'd2,  4'b0010, 1'b1},
    {16'h2023, 4'd2,  4'b0001, 1'b0},
    {16'h1900, 4'd2,  4'b0001, 1'b0},
    {16'h2000, 4'd2,  4'b0010, 1'b1},
    {16'h0000, 4'd2,  4'b0010, 1'b1},
    {16'h1996, 4'd4,  4'b0100, 1'b1},
    {16'h2011, 4'd11, 4'b0100, 1'b0},
    {16'h1999, 4'd12, 4'b1000, 1'b0},
    {16'h2012, 4'd1,  4'b1000, 1'b1},
    {16'h2100, 4'd0,  4'b0000, 1'b0},
    {16'h2400, 4'd13, 4'b0000, 1'b1},
    {16'h1976, 4'd15, 4'b0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic [15:0] year_bcd = '0;
  logic [3:0]  month = '0;
  logic        leap_year;
  logic [3:0]  days_onehot;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cal_month_days dut (
    .year_bcd    (year_bcd),
    .month       (month),
    .leap_year   (leap_year),
    .days_onehot (days_onehot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic logic [3:0] ref_days(int m, logic lp);
    case (m)
      2: return lp ? 4'b0010 : 4'b0001;
      4, 6, 9, 11: return 4'b0100;
      1, 3, 5, 7, 8, 10, 12: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [15:0] to_bcd(int y);
    return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  function automatic string req_of(int m);
    if (m == 2) return "R6";
    if (m == 4 || m == 6 || m == 9 || m == 11) return "R7";
    if (m >= 1 && m <= 12) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s year=%h month=%0d actual=%b expected=%b", req, year_bcd, month, act, exp);
    end
  endtask

  initial begin
    // Vector table: R1 digit layout, leap rules and month classes
    for (int i = 0; i < NVEC; i++) begin
      year_bcd = VECS[i][24:9];
      month    = VECS[i][8:5];
      #1;
      check("R1_R2_R3_R4_R5 leap", {3'b0, leap_year}, {3'b0, VECS[i][0]});
      check(req_of(int'(VECS[i][8:5])), days_onehot, VECS[i][4:1]);
    end

    // Directed century corners
    year_bcd = 16'h1800; month = 4'd2; #1;
    check("R3 century", {3'b0, leap_year}, 4'b0000);
    check("R6 century feb", days_onehot, 4'b0001);
    year_bcd = 16'h1600; #1;
    check("R4 quad century", {3'b0, leap_year}, 4'b0001);
    year_bcd = 16'h0400; #1;
    check("R4 quad century", {3'b0, leap_year}, 4'b0001);
    year_bcd = 16'h0004; #1;
    check("R2 year four", {3'b0, leap_year}, 4'b0001);
    year_bcd = 16'h0010; #1;
    check("R5 year ten", {3'b0, leap_year}, 4'b0000);

    // Exhaustive sweep against modulo reference
    for (int y = 0; y < 10000; y++) begin
      logic lp;
      lp = ref_leap(y);
      year_bcd = to_bcd(y);
      for (int m = 0; m < 16; m++) begin
        month = 4'(m);
        #1;
        if (m == 0) begin
          if (y % 400 == 0) check("R4", {3'b0, leap_year}, {3'b0, lp});
          else if (y % 100 == 0) check("R3", {3'b0, leap_year}, {3'b0, lp});
          else if (y % 4 == 0) check("R2", {3'b0, leap_year}, {3'b0, lp});
          else check("R5", {3'b0, leap_year}, {3'b0, lp});
        end
        check(req_of(m), days_onehot, ref_days(m, lp));
        if (m >= 1 && m <= 12)
          check("R10 one bit", 4'($countones(days_onehot)), 4'd1);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule